// File: doc/BRIEF.md
# Destination Message Queue with Acknowledge Resource Pool

This block sits on the receive side of a node and accepts incoming messages one per cycle over a valid/ready handshake. Each accepted message is written into a circular queue of fixed depth. Software reads the oldest entry through a head port and retires it with a pop strobe. A level interrupt stays high for as long as at least one entry is waiting.

The block also keeps a small pool of acknowledge resources. A message can ask to be acknowledged by software. For such a message the block takes the lowest-numbered free resource and marks it busy. It then writes that resource's one-hot bit into the top byte of the stored entry, so software knows which resource to give back. A message that does not ask for acknowledgment is stored with a zero in that byte and takes no resource. Software frees resources by writing a bit mask. When every resource is busy, messages that ask for acknowledgment are held off. Messages that do not ask for acknowledgment still get through.

Top module: `dest_payload_queue`

## Requirements
- R1: After reset the interrupt output is low and the input ready output is high.
- R2: Accepted messages come out of the head port in arrival order, with the message data in bits 119:0 of the head entry. A pop strobe moves the head to the next entry.
- R3: A message with its acknowledge request set is stored with the one-hot bit of the lowest-indexed free resource in bits 127:120 (bit 120 stands for resource 0). That resource becomes busy.
- R4: A message without the acknowledge request is stored with bits 127:120 equal to zero and leaves the resource pool unchanged.
- R5: When 17 entries are held, input ready is low and no message is accepted. After a pop, new entries are accepted again and the storage wraps around.
- R6: When all 8 resources are busy, input ready is low for a message that requests acknowledgment and high for one that does not, unless the queue is full.
- R7: An acknowledge write with a mask frees every busy resource whose mask bit is 1, and the next allocation reuses the lowest freed index.
- R8: An acknowledge write naming a resource that is already free has no effect on later allocation.
- R9: A pop strobe while the queue is empty is ignored.
- R10: The interrupt output is high exactly while the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming message valid |
| inReady | output | 1 | Block can take the incoming message |
| inAckReq | input | 1 | Incoming message asks for software acknowledgment |
| inData | input | 120 | Incoming message data |
| headData | output | 128 | Oldest stored entry: resource vector in 127:120, data in 119:0 |
| pop | input | 1 | Retire the head entry |
| ackWr | input | 1 | Acknowledge write strobe |
| ackMask | input | 8 | Resources to free, one bit per resource |
| irq | output | 1 | Level interrupt, high while the queue is not empty |

## Verification
The bench builds the block with its default parameters: a depth of 17 and 8 resources. With a depth that is not a power of two, filling the queue and pushing once more after a pop exercises the pointer wrap at index 16. With 8 resources, eight flagged messages exhaust the pool, which makes the split ready behaviour and the reuse of freed indices reachable in a short run.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // write the entry at the write pointer
    logic stampEn;  // stamp the allocated resource bit into the entry
  } dpqCtl_t;
endpackage

// File: rtl/dpq_ctrl.sv
module dpq_ctrl
  import dpq_pkg::*;
#(
  parameter int DEPTH   = 17,
  parameter int NUM_RES = 8,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inAckReq,
  input  logic               pop,
  input  logic               ackWr,
  input  logic [NUM_RES-1:0] ackMask,
  output logic               inReady,
  output logic               irq,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [NUM_RES-1:0] allocVec,
  output dpqCtl_t            ctl,
  output logic [NUM_RES-1:0] resBusy,
  output logic [CNT_W-1:0]   fillLevel
);
  logic full, empty, resAvail, accept, doPop, takeRes;
  logic [NUM_RES-1:0] freeMask, setMask;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Lowest-index free resource, descending scan so the lowest wins
  always_comb begin
    allocVec = '0;
    for (int i = NUM_RES - 1; i >= 0; i--) begin
      if (!resBusy[i]) begin
        allocVec    = '0;
        allocVec[i] = 1'b1;
      end
    end
  end

  assign full     = (fillLevel == CNT_W'(DEPTH));
  assign empty    = (fillLevel == '0);
  assign resAvail = ~&resBusy;
  assign inReady  = !full && (!inAckReq || resAvail);
  assign accept   = inValid && inReady;
  assign doPop    = pop && !empty;
  assign takeRes  = accept && inAckReq;
  assign irq      = !empty;

  assign ctl.wrEn    = accept;
  assign ctl.stampEn = inAckReq;

  assign freeMask = ackWr ? ackMask : '0;
  assign setMask  = takeRes ? allocVec : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
      resBusy   <= '0;
    end else begin
      if (accept) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({accept, doPop})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
      resBusy <= (resBusy & ~freeMask) | setMask;
    end
  end
endmodule

// File: rtl/dpq_datapath.sv
module dpq_datapath
  import dpq_pkg::*;
#(
  parameter int DEPTH   = 17,
  parameter int NUM_RES = 8,
  parameter int DATA_W  = 120,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int ENTRY_W = DATA_W + NUM_RES
) (
  input  logic               clk,
  input  dpqCtl_t            ctl,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [PTR_W-1:0]   rdPtr,
  input  logic [NUM_RES-1:0] allocVec,
  input  logic [DATA_W-1:0]  inData,
  output logic [ENTRY_W-1:0] headData
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [NUM_RES-1:0] stamp;

  assign stamp = ctl.stampEn ? allocVec : '0;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[wrPtr] <= {stamp, inData};
  end

  assign headData = mem[rdPtr];
endmodule

// File: rtl/dest_payload_queue.sv
module dest_payload_queue
  import dpq_pkg::*;
#(
  parameter int DEPTH   = 17,
  parameter int NUM_RES = 8,
  parameter int DATA_W  = 120
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic                      inAckReq,
  input  logic [DATA_W-1:0]         inData,
  output logic [DATA_W+NUM_RES-1:0] headData,
  input  logic                      pop,
  input  logic                      ackWr,
  input  logic [NUM_RES-1:0]        ackMask,
  output logic                      irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  dpqCtl_t            ctl;
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [NUM_RES-1:0] allocVec, resBusy;
  logic [CNT_W-1:0]   fillLevel;

  dpq_ctrl #(.DEPTH(DEPTH), .NUM_RES(NUM_RES), .PTR_W(PTR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk, .rstN, .inValid, .inAckReq, .pop, .ackWr, .ackMask,
    .inReady, .irq, .wrPtr, .rdPtr, .allocVec, .ctl, .resBusy, .fillLevel
  );

  dpq_datapath #(.DEPTH(DEPTH), .NUM_RES(NUM_RES), .DATA_W(DATA_W), .PTR_W(PTR_W)) i_dp (
    .clk, .ctl, .wrPtr, .rdPtr, .allocVec, .inData, .headData
  );
endmodule

// File: rtl/dest_payload_queue_chk.sv
module dest_payload_queue_chk #(
  parameter int DEPTH   = 17,
  parameter int NUM_RES = 8,
  parameter int DATA_W  = 120,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic                      inReady,
  input logic                      inAckReq,
  input logic                      pop,
  input logic                      ackWr,
  input logic [NUM_RES-1:0]        ackMask,
  input logic                      irq,
  input logic [DATA_W+NUM_RES-1:0] headData,
  input logic [NUM_RES-1:0]        resBusy,
  input logic [CNT_W-1:0]          fillLevel
);
  p_stamp_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $onehot0(headData[DATA_W+NUM_RES-1:DATA_W]));

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == CNT_W'(DEPTH)) |-> !inReady);

  p_ack_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (&resBusy && inAckReq) |-> !inReady);

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && !(inValid && inReady && inAckReq)) |=>
      resBusy == ($past(resBusy) & ~$past(ackMask)));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == '0 && pop && !inValid) |=> fillLevel == '0);

  p_irq_after_push_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !pop) |=> irq);
endmodule

bind dest_payload_queue dest_payload_queue_chk #(
  .DEPTH(DEPTH), .NUM_RES(NUM_RES), .DATA_W(DATA_W)
) i_chk (
  .clk, .rstN, .inValid, .inReady, .inAckReq, .pop, .ackWr, .ackMask,
  .irq, .headData, .resBusy, .fillLevel
);

// File: tb/test_dest_payload_queue.sv
`timescale 1ns/1ps
module test_dest_payload_queue;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic         inAckReq = 1'b0;
  logic [119:0] inData = '0;
  logic [127:0] headData;
  logic         pop = 1'b0;
  logic         ackWr = 1'b0;
  logic [7:0]   ackMask = '0;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dest_payload_queue i_dest_payload_queue (
    .clk, .rstN, .inValid, .inReady, .inAckReq, .inData, .headData,
    .pop, .ackWr, .ackMask, .irq
  );

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pushOne(input logic [119:0] d, input logic ack);
    @(negedge clk);
    inValid = 1'b1; inAckReq = ack; inData = d;
    @(negedge clk);
    inValid = 1'b0; inAckReq = 1'b0;
  endtask

  task automatic popCheck(input logic [119:0] d, input logic [7:0] vec, input string req);
    @(negedge clk);
    chk(headData, {vec, d}, req);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic ackWrite(input logic [7:0] m);
    @(negedge clk);
    ackWr = 1'b1; ackMask = m;
    @(negedge clk);
    ackWr = 1'b0; ackMask = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(irq, 1'b0, "R1 irq after reset");
    chk(inReady, 1'b1, "R1 ready after reset");
  endtask

  task automatic t_basic();
    pushOne(120'hA, 1'b1);
    @(negedge clk);
    chk(irq, 1'b1, "R10 irq with entry");
    pushOne(120'hB, 1'b0);
    pushOne(120'hC, 1'b1);
    popCheck(120'hA, 8'h01, "R3 first flagged entry");
    popCheck(120'hB, 8'h00, "R4 unflagged entry");
    popCheck(120'hC, 8'h02, "R2 R3 second flagged entry");
    @(negedge clk);
    chk(irq, 1'b0, "R10 irq after draining");
    ackWrite(8'h03);
  endtask

  task automatic t_exhaust();
    for (int i = 0; i < 8; i++) pushOne(120'(i), 1'b1);
    @(negedge clk);
    inValid = 1'b1; inAckReq = 1'b1; inData = 120'h99;
    #1 chk(inReady, 1'b0, "R6 flagged stalls when pool exhausted");
    inAckReq = 1'b0;
    #1 chk(inReady, 1'b1, "R6 unflagged passes when pool exhausted");
    @(negedge clk);
    inValid = 1'b0;
    ackWrite(8'h24);
    pushOne(120'hA0, 1'b1);
    pushOne(120'hA1, 1'b1);
    for (int i = 0; i < 8; i++) popCheck(120'(i), 8'(1 << i), "R3 allocation order");
    popCheck(120'h99, 8'h00, "R4 unflagged during exhaustion");
    popCheck(120'hA0, 8'h04, "R7 reuse lowest freed");
    popCheck(120'hA1, 8'h20, "R7 reuse next freed");
    ackWrite(8'hFF);
  endtask

  task automatic t_noeffect();
    pushOne(120'hD1, 1'b1);
    pushOne(120'hD2, 1'b1);
    ackWrite(8'h01);
    ackWrite(8'h01);
    ackWrite(8'h04);
    pushOne(120'hD3, 1'b1);
    pushOne(120'hD4, 1'b1);
    popCheck(120'hD1, 8'h01, "R3 D1");
    popCheck(120'hD2, 8'h02, "R3 D2");
    popCheck(120'hD3, 8'h01, "R8 repeated free of resource 0");
    popCheck(120'hD4, 8'h04, "R8 free of idle resource 2");
    ackWrite(8'hFF);
  endtask

  task automatic t_full();
    for (int i = 0; i < 17; i++) pushOne(120'h100 + 120'(i), 1'b0);
    @(negedge clk);
    inValid = 1'b1; inData = 120'h1FF;
    #1 chk(inReady, 1'b0, "R5 ready low when full");
    @(negedge clk);
    inValid = 1'b0;
    popCheck(120'h100, 8'h00, "R5 head while full");
    pushOne(120'h200, 1'b0);
    for (int i = 1; i < 17; i++) popCheck(120'h100 + 120'(i), 8'h00, "R2 R5 order");
    popCheck(120'h200, 8'h00, "R5 wrapped entry");
    @(negedge clk);
    chk(irq, 1'b0, "R10 irq after full drain");
  endtask

  task automatic t_emptyPop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pop = 1'b0;
    chk(irq, 1'b0, "R9 empty pop keeps irq low");
    pushOne(120'h300, 1'b0);
    @(negedge clk);
    chk(irq, 1'b1, "R9 irq after push following empty pops");
    chk(headData, {8'h00, 120'h300}, "R9 head after empty pops");
    popCheck(120'h300, 8'h00, "R2 single entry");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_exhaust();
    t_noeffect();
    t_full();
    t_emptyPop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule